// File: doc/BRIEF.md
# Nonvolatile Memory Command Register

This block is an 8-bit control register that a host uses to drive an on-chip nonvolatile array. The register holds two target-select bits: one picks the program array over the data array, and one picks configuration space. It also holds a row-erase enable, a write-enable gate and a write-error flag. Two command bits start operations. Software can only set these two bits. The hardware clears them when the operation ends.

A read command lasts a single cycle. A write or erase command is self-timed. The request stays on the memory side for at least `PROG_CYCLES` clock cycles, and it stays until the memory reports done. A write issued with row-erase enabled removes the whole row that contains the current address. A warm reset that arrives while a write is in flight does not clear everything. It leaves the error flag set and keeps the select bits, so software can tell which operation was lost.

The host port is a plain register write strobe with readback and no back-pressure: every strobe is taken in the cycle it is presented. The memory side is a level request. `mem_req` is the valid and `mem_done` is the ready. A write or erase request stays asserted and unchanged until the register sees done after the minimum time has passed. A read request is a one-cycle strobe that needs no acknowledge.

Top module: `nvm_ctl`

## Requirements
- R1: After power-on reset (`por_n` low at a clock edge) `reg_rdata` reads 0x00 and `mem_req` is 0.
- R2: While no write is in flight, a host write loads bit 7 (program select), bit 6 (config select), bit 4 (row-erase), bit 3 (error flag) and bit 2 (write enable). Bit 5 always reads 0, so writing 0xFC reads back 0xDC.
- R3: Writing 1 to bit 0 (read command) sets it for exactly one cycle. During that cycle `mem_req`=1, `mem_op`=1 (read) and `mem_addr` equals `addr_in`. The bit then reads 0.
- R4: A request to set bit 0 is ignored when bit 7, as it stands before the write, is 1.
- R5: Writing 1 to bit 1 (write command) while bit 2 is already 1 sets bit 1 and raises `mem_req`. Writing 0 to bit 1 while it is 1 has no effect. The read and write commands are never 1 together, and the write command wins if both are written at once.
- R6: Writing 1 to bit 1 while the stored bit 2 is 0 does nothing: bit 1 stays 0 and `mem_req` stays 0.
- R7: The write command stays 1 until the clock edge of the first cycle where at least `PROG_CYCLES` cycles have elapsed and `mem_done` has been seen. With done always high it reads 1 for exactly `PROG_CYCLES` cycles.
- R8: During a write, `mem_addr` is `addr_in` captured at the start, and later changes to `addr_in` do not affect it. `mem_op` is 3 (erase) with the low `ROW_BITS` address bits forced to 0 when bit 4 is 1, and 2 (write) otherwise. `mem_cfg` equals bit 6, and `mem_prog` is bit 7 AND NOT bit 6.
- R9: A normal completion clears bit 1, bit 4 and the error flag (bit 3). Bit 2 and the select bits are unchanged.
- R10: While bit 1 is 1, host writes change no bit and cannot start a read.
- R11: A warm reset (`wrst_n` low at an edge) during a write sets bit 3. It keeps bits 7 and 6, clears bits 4, 2, 1 and 0, and drops `mem_req`.
- R12: A warm reset with no write in flight keeps bits 7, 6 and 3 and clears the rest. A power-on reset also clears bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous, clears everything |
| wrst_n | input | 1 | Warm reset, active low, synchronous, keeps selects and error flag |
| reg_we | input | 1 | Host write strobe |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Current register value |
| addr_in | input | AW | Memory address pointer supplied by the host side |
| mem_req | output | 1 | Memory request (valid) |
| mem_op | output | 2 | 0 idle, 1 read, 2 write, 3 row erase |
| mem_addr | output | AW | Address for the memory operation |
| mem_prog | output | 1 | Target is the program array |
| mem_cfg | output | 1 | Target is configuration space |
| mem_done | input | 1 | Memory completion (ready) |

## Verification
Each host write is presented at a falling edge, and its effect is checked at the next falling edge, one register stage later. A read strobe is checked at that same point, and its clearing is checked one cycle after that. For write length, the bench counts the falling edges on which bit 1 reads 1 and compares the count with `PROG_CYCLES`. When done is delayed, it raises `mem_done` at a falling edge and expects bit 1 to read 0 at the following falling edge. A reset pulse spans one rising edge, and the register is read back at the falling edge that releases it.

// File: rtl/nvm_ctl_pkg.sv
package nvm_ctl_pkg;
  localparam int B_PROG  = 7;
  localparam int B_CFG   = 6;
  localparam int B_ERASE = 4;
  localparam int B_ERR   = 3;
  localparam int B_WREN  = 2;
  localparam int B_WR    = 1;
  localparam int B_RD    = 0;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_ERASE = 2'd3
  } mem_op_e;
endpackage

// File: rtl/nvm_ctl_bits.sv
module nvm_ctl_bits
  import nvm_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       wrst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic       complete,
  output logic       prog_sel,
  output logic       cfg_sel,
  output logic       erase_en,
  output logic       wr_err,
  output logic       wr_en,
  output logic       wr_cmd,
  output logic       rd_cmd,
  output logic       start
);
  logic busy;
  logic host_ok;
  logic rd_set;

  assign busy    = wr_cmd;
  assign host_ok = we && !busy;
  // write command accepted only with the gate already open
  assign start   = host_ok && wdata[B_WR] && wr_en;
  // read refused while program array selected; write command wins
  assign rd_set  = host_ok && wdata[B_RD] && !prog_sel && !rd_cmd && !start;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      prog_sel <= 1'b0;
      cfg_sel  <= 1'b0;
      erase_en <= 1'b0;
      wr_err   <= 1'b0;
      wr_en    <= 1'b0;
      wr_cmd   <= 1'b0;
      rd_cmd   <= 1'b0;
    end else if (!wrst_n) begin
      wr_err   <= wr_err | wr_cmd;
      erase_en <= 1'b0;
      wr_en    <= 1'b0;
      wr_cmd   <= 1'b0;
      rd_cmd   <= 1'b0;
    end else begin
      rd_cmd <= rd_set;
      if (host_ok) begin
        prog_sel <= wdata[B_PROG];
        cfg_sel  <= wdata[B_CFG];
        erase_en <= wdata[B_ERASE];
        wr_err   <= wdata[B_ERR];
        wr_en    <= wdata[B_WREN];
      end
      if (start) begin
        wr_cmd <= 1'b1;
      end else if (complete) begin
        wr_cmd   <= 1'b0;
        erase_en <= 1'b0;
        wr_err   <= 1'b0;
      end
    end
  end

  p_rd_pulse_r3: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
    rd_cmd |=> !rd_cmd);

  p_rd_prog_r4: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
    $rose(rd_cmd) |-> !$past(prog_sel));

  p_wr_gate_r6: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
    $rose(wr_cmd) |-> $past(wr_en));

  p_lock_r10: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
    (wr_cmd && $past(wr_cmd)) |-> $stable({prog_sel, cfg_sel, erase_en, wr_en}));
endmodule

// File: rtl/nvm_ctl_seq.sv
module nvm_ctl_seq #(
  parameter int AW          = 16,
  parameter int ROW_BITS    = 6,
  parameter int PROG_CYCLES = 16
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          wrst_n,
  input  logic          start,
  input  logic          busy,
  input  logic          erase_en,
  input  logic [AW-1:0] addr_in,
  input  logic          mem_done,
  output logic          complete,
  output logic [AW-1:0] wr_addr
);
  localparam int LAST = PROG_CYCLES - 1;
  localparam int CW   = $clog2(PROG_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          done_seen;
  logic [AW-1:0] addr_lat;
  logic          timer_up;

  assign timer_up = (cnt == CW'(LAST));
  assign complete = busy && timer_up && (mem_done || done_seen);

  always_ff @(posedge clk) begin
    if (!por_n || !wrst_n) begin
      cnt       <= '0;
      done_seen <= 1'b0;
      addr_lat  <= '0;
    end else if (start) begin
      cnt       <= '0;
      done_seen <= 1'b0;
      addr_lat  <= addr_in;
    end else if (busy) begin
      if (!timer_up) cnt <= cnt + 1'b1;
      if (mem_done) done_seen <= 1'b1;
    end
  end

  generate
    if (ROW_BITS > 0) begin : g_row
      assign wr_addr = erase_en ? {addr_lat[AW-1:ROW_BITS], {ROW_BITS{1'b0}}} : addr_lat;
    end else begin : g_flat
      assign wr_addr = addr_lat;
    end
  endgenerate

  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
    (busy && $past(busy)) |-> $stable(addr_lat));
endmodule

// File: rtl/nvm_ctl.sv
module nvm_ctl
  import nvm_ctl_pkg::*;
#(
  parameter int AW          = 16,
  parameter int ROW_BITS    = 6,
  parameter int PROG_CYCLES = 16
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          wrst_n,
  input  logic          reg_we,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic [AW-1:0] addr_in,
  output logic          mem_req,
  output logic [1:0]    mem_op,
  output logic [AW-1:0] mem_addr,
  output logic          mem_prog,
  output logic          mem_cfg,
  input  logic          mem_done
);
  logic prog_sel, cfg_sel, erase_en, wr_err, wr_en, wr_cmd, rd_cmd;
  logic start, complete;
  logic [AW-1:0] wr_addr;
  mem_op_e op;

  nvm_ctl_bits u_bits (
    .clk      (clk),
    .por_n    (por_n),
    .wrst_n   (wrst_n),
    .we       (reg_we),
    .wdata    (reg_wdata),
    .complete (complete),
    .prog_sel (prog_sel),
    .cfg_sel  (cfg_sel),
    .erase_en (erase_en),
    .wr_err   (wr_err),
    .wr_en    (wr_en),
    .wr_cmd   (wr_cmd),
    .rd_cmd   (rd_cmd),
    .start    (start)
  );

  nvm_ctl_seq #(
    .AW          (AW),
    .ROW_BITS    (ROW_BITS),
    .PROG_CYCLES (PROG_CYCLES)
  ) u_seq (
    .clk      (clk),
    .por_n    (por_n),
    .wrst_n   (wrst_n),
    .start    (start),
    .busy     (wr_cmd),
    .erase_en (erase_en),
    .addr_in  (addr_in),
    .mem_done (mem_done),
    .complete (complete),
    .wr_addr  (wr_addr)
  );

  always_comb begin
    if (rd_cmd)      op = OP_READ;
    else if (wr_cmd) op = erase_en ? OP_ERASE : OP_WRITE;
    else             op = OP_IDLE;
  end

  assign mem_op    = op;
  assign mem_req   = rd_cmd | wr_cmd;
  assign mem_addr  = wr_cmd ? wr_addr : addr_in;
  assign mem_cfg   = cfg_sel;
  assign mem_prog  = prog_sel & ~cfg_sel;
  assign reg_rdata = {prog_sel, cfg_sel, 1'b0, erase_en, wr_err, wr_en, wr_cmd, rd_cmd};

  p_one_cmd_r5: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
    $onehot0({rd_cmd, wr_cmd}));

  p_erase_row_r8: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
    (mem_req && mem_op == OP_ERASE) |-> (mem_addr[ROW_BITS-1:0] == '0));
endmodule

// File: tb/sim_nvm_ctl.sv
`timescale 1ns/1ps
module sim_nvm_ctl;
  import nvm_ctl_pkg::*;
  localparam int AW = 16;
  localparam int RB = 6;
  localparam int PC = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic por_n = 1'b0, wrst_n = 1'b1, reg_we = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [AW-1:0] addr_in = '0, mem_addr;
  logic mem_req, mem_prog, mem_cfg, mem_done;
  logic [1:0] mem_op;
  logic done_auto = 1'b1, done_force = 1'b0;
  int checks = 0, errors = 0;

  assign mem_done = done_auto ? mem_req : done_force;

  nvm_ctl #(.AW(AW), .ROW_BITS(RB), .PROG_CYCLES(PC)) u0 (
    .clk(clk), .por_n(por_n), .wrst_n(wrst_n), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .addr_in(addr_in),
    .mem_req(mem_req), .mem_op(mem_op), .mem_addr(mem_addr),
    .mem_prog(mem_prog), .mem_cfg(mem_cfg), .mem_done(mem_done)
  );

  task automatic chk(input string r, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] v);
    @(negedge clk); reg_we = 1'b1; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (reg_rdata[1]) n++; else break;
    end
  endtask

  task automatic pulse_wrst();
    @(negedge clk); wrst_n = 1'b0;
    @(negedge clk); wrst_n = 1'b1;
  endtask

  task automatic t_por();
    chk("R1", "rdata", 16'(reg_rdata), 16'h00);
    chk("R1", "req", 16'(mem_req), 16'h0);
  endtask

  task automatic t_fields();
    reg_wr(8'hFC);
    chk("R2", "rdata", 16'(reg_rdata), 16'hDC);
    reg_wr(8'h00);
    chk("R2", "cleared", 16'(reg_rdata), 16'h00);
  endtask

  task automatic t_read();
    addr_in = 16'h0042;
    reg_wr(8'h01);
    chk("R3", "rd bit", 16'(reg_rdata), 16'h01);
    chk("R3", "req", 16'(mem_req), 16'h1);
    chk("R3", "op", 16'(mem_op), 16'(OP_READ));
    chk("R3", "addr", mem_addr, 16'h0042);
    @(negedge clk);
    chk("R3", "rd cleared", 16'(reg_rdata), 16'h00);
    chk("R3", "req low", 16'(mem_req), 16'h0);
  endtask

  task automatic t_read_prog();
    reg_wr(8'h80);
    reg_wr(8'h81);
    chk("R4", "rd refused", 16'(reg_rdata), 16'h80);
    chk("R4", "req", 16'(mem_req), 16'h0);
    reg_wr(8'h00);
  endtask

  task automatic t_no_wren();
    reg_wr(8'h02);
    chk("R6", "rdata", 16'(reg_rdata), 16'h00);
    chk("R6", "req", 16'(mem_req), 16'h0);
    repeat (3) @(negedge clk);
    chk("R6", "req later", 16'(mem_req), 16'h0);
  endtask

  task automatic t_write();
    int n;
    done_auto = 1'b1;
    addr_in = 16'h1234;
    reg_wr(8'h04);
    reg_wr(8'h06);
    chk("R5", "wr set", 16'(reg_rdata), 16'h06);
    chk("R5", "req", 16'(mem_req), 16'h1);
    chk("R8", "op", 16'(mem_op), 16'(OP_WRITE));
    chk("R8", "addr", mem_addr, 16'h1234);
    addr_in = 16'hFFFF;
    @(negedge clk);
    chk("R8", "addr held", mem_addr, 16'h1234);
    wait_idle(n);
    chk("R7", "length", 16'(n + 1), 16'(PC));
    chk("R9", "after done", 16'(reg_rdata), 16'h04);
    chk("R9", "req low", 16'(mem_req), 16'h0);
  endtask

  task automatic t_late_and_lock();
    done_auto = 1'b0; done_force = 1'b0;
    reg_wr(8'h06);
    repeat (10) @(negedge clk);
    chk("R7", "held for done", 16'(reg_rdata), 16'h06);
    reg_wr(8'h00);
    chk("R5", "wr not cleared by sw", 16'(reg_rdata), 16'h06);
    reg_wr(8'hD9);
    chk("R10", "locked", 16'(reg_rdata), 16'h06);
    chk("R10", "op", 16'(mem_op), 16'(OP_WRITE));
    done_force = 1'b1;
    @(negedge clk);
    chk("R7", "ends on done", 16'(reg_rdata), 16'h04);
    done_force = 1'b0;
  endtask

  task automatic t_erase();
    int n;
    done_auto = 1'b1;
    addr_in = 16'h12BF;
    reg_wr(8'h94);
    reg_wr(8'h96);
    chk("R8", "op", 16'(mem_op), 16'(OP_ERASE));
    chk("R8", "row addr", mem_addr, 16'h1280);
    chk("R8", "prog", 16'(mem_prog), 16'h1);
    chk("R8", "cfg", 16'(mem_cfg), 16'h0);
    wait_idle(n);
    chk("R9", "erase cleared", 16'(reg_rdata), 16'h84);
    reg_wr(8'h00);
  endtask

  task automatic t_warm();
    int n;
    done_auto = 1'b0; done_force = 1'b0;
    reg_wr(8'hC4);
    reg_wr(8'hC6);
    chk("R8", "cfg overrides", 16'({mem_cfg, mem_prog}), 16'h2);
    pulse_wrst();
    chk("R11", "after wrst", 16'(reg_rdata), 16'hC8);
    chk("R11", "req", 16'(mem_req), 16'h0);
    pulse_wrst();
    chk("R12", "idle wrst", 16'(reg_rdata), 16'hC8);
    done_auto = 1'b1;
    reg_wr(8'h0C);
    reg_wr(8'h0E);
    wait_idle(n);
    chk("R9", "err cleared", 16'(reg_rdata), 16'h04);
    reg_wr(8'hC8);
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    chk("R12", "por clears err", 16'(reg_rdata), 16'h00);
    chk("R1", "req after por", 16'(mem_req), 16'h0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    t_por();
    t_fields();
    t_read();
    t_read_prog();
    t_no_wren();
    t_write();
    t_late_and_lock();
    t_erase();
    t_warm();
    finish_run();
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule